// File: doc/BRIEF.md
# Call, Return and Trap Context Sequencer

This block carries out the stack-frame part of four control-transfer operations for a 16-bit machine with a byte-wide memory. It handles a subroutine call, a return that also drops 0 to 7 bytes of local storage, trap entry, and return from trap. Trap entry is the path every unimplemented opcode takes. That includes the decimal input/output and string output instructions and the no-operation traps.

The surrounding core keeps the architectural registers: stack pointer, program counter, accumulator, index register and the four condition flags. When it pulses `start` it presents their current values together with the operation code, the local-byte count, the instruction byte being trapped and the computed call target. The sequencer takes a snapshot of these values. It then runs one memory byte access per cycle and pulses `done`. While `done` is high, the `res_*` outputs hold the new register values, and they stay valid until the next accepted command.

Trap entry builds a fixed 10-byte context frame on a system stack. It finds the top of that stack and the handler address in two vector words just below the vector base. Writes to addresses at or above the ROM boundary are dropped. The access still uses its cycle.

Top module: `ctx_sequencer`

## Requirements
- R1: Call (`op`=0) writes the current PC as a word at SP−2: the high byte goes to SP−2 and the low byte to SP−1. It then returns SP−2 as the new SP and the call target as the new PC. A, X and the flags stay unchanged.
- R2: Return (`op`=1) with `ret_n`=n reads the new PC as a word from SP+n (high byte) and SP+n+1 (low byte). It returns SP+n+2 as the new SP, never writes memory, and leaves A, X and the flags unchanged.
- R3: Trap entry (`op`=2) reads the system-stack top T as a word at VEC_BASE−5. It reads the new PC as a word at VEC_BASE−1.
- R4: Trap entry writes the instruction byte at T−1. It writes the old SP at T−3, the old PC at T−5, X at T−7 and A at T−9, each as a word with the high byte at the lower address. It writes the flag byte {0000,N,Z,V,C} at T−10.
- R5: Trap entry returns T−10 as the new SP and leaves A, X and the flags unchanged.
- R6: Return from trap (`op`=3) takes N, Z, V and C from bits 3, 2, 1 and 0 of the byte at SP.
- R7: Return from trap loads A from the word at SP+1, X from SP+3, PC from SP+5 and finally SP from SP+7.
- R8: A write whose address is at or above ROM_BASE is suppressed (`mem_we` low) but still uses its access cycle.
- R9: Each command makes exactly one byte access per cycle. Call and return make 2 accesses, trap entry 14 and return from trap 9. `done` is a one-cycle pulse in the cycle after the last access.
- R10: `start` is ignored while `busy` is high, including the cycle in which `done` is high.
- R11: After reset, `busy`, `done` and `mem_en` are low.
- R12: Stack address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when idle |
| op | input | 2 | 0 call, 1 return, 2 trap entry, 3 return from trap |
| ret_n | input | 3 | Local bytes dropped by a return |
| cur_sp | input | 16 | Current stack pointer |
| cur_pc | input | 16 | Current program counter (return address for a call) |
| cur_a | input | 16 | Current accumulator |
| cur_x | input | 16 | Current index register |
| cur_flags | input | 4 | Current flags {N,Z,V,C} |
| cur_ir | input | 8 | Instruction byte being trapped |
| call_target | input | 16 | Computed call destination |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sp | output | 16 | New stack pointer |
| res_pc | output | 16 | New program counter |
| res_a | output | 16 | New accumulator |
| res_x | output | 16 | New index register |
| res_flags | output | 4 | New flags {N,Z,V,C} |
| mem_en | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid before the end of the access cycle |

## Verification
Two things can land in the same cycle: a new `start` request and a command that is still running, and that includes its `done` cycle. The bench raises `start` with a different operation code partway through a trap entry. It raises it again in the exact cycle that `done` is seen. The sequence is judged correct if the access count stays at 14, the results match the first command, and no further memory access or `busy` follows the late request. A second overlap is the ROM guard acting inside a single trap frame. A frame placed just above the boundary must have its upper bytes dropped and its lower bytes stored within the same command.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;
    localparam int STEP_W = 4;
    localparam int NLOC_W = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        OP_CALL  = 2'd0,
        OP_RET   = 2'd1,
        OP_TRAP  = 2'd2,
        OP_RETTR = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        DST_NONE,
        DST_PC_HI, DST_PC_LO,
        DST_TOP_HI, DST_TOP_LO,
        DST_FLG,
        DST_A_HI, DST_A_LO,
        DST_X_HI, DST_X_LO,
        DST_SP_HI, DST_SP_LO
    } dst_e;

    typedef struct packed {
        word_t             sp;
        word_t             pc;
        word_t             a;
        word_t             x;
        logic [FLAG_W-1:0] flags;
    } ctx_t;

    typedef struct packed {
        logic  en;
        logic  wr;
        word_t addr;
        byte_t wdata;
        dst_e  dst;
    } access_t;

    function automatic step_t op_steps(op_e op);
        case (op)
            OP_CALL:  return step_t'(2);
            OP_RET:   return step_t'(2);
            OP_TRAP:  return step_t'(14);
            default:  return step_t'(9);
        endcase
    endfunction

    function automatic byte_t hi_b(word_t w);
        return w[WORD_W-1 -: BYTE_W];
    endfunction

    function automatic byte_t lo_b(word_t w);
        return w[BYTE_W-1:0];
    endfunction

    function automatic access_t rd_at(word_t addr, dst_e dst);
        access_t r;
        r.en = 1'b1; r.wr = 1'b0; r.addr = addr; r.wdata = '0; r.dst = dst;
        return r;
    endfunction

    function automatic access_t wr_at(word_t addr, byte_t data);
        access_t r;
        r.en = 1'b1; r.wr = 1'b1; r.addr = addr; r.wdata = data; r.dst = DST_NONE;
        return r;
    endfunction

    // One byte access per step; the sequence per operation is fixed.
    function automatic access_t plan_step(op_e op, step_t k, logic [NLOC_W-1:0] n,
                                          ctx_t c, byte_t ir, word_t top, word_t vec);
        access_t r;
        word_t   base;
        int      idx;
        r   = '0;
        idx = int'(k);
        case (op)
            OP_CALL: begin
                base = c.sp - word_t'(2);
                if (idx == 0) r = wr_at(base, hi_b(c.pc));
                else          r = wr_at(base + word_t'(1), lo_b(c.pc));
            end
            OP_RET: begin
                base = c.sp + word_t'(n);
                if (idx == 0) r = rd_at(base, DST_PC_HI);
                else          r = rd_at(base + word_t'(1), DST_PC_LO);
            end
            OP_TRAP: begin
                case (idx)
                    0:  r = rd_at(vec - word_t'(5), DST_TOP_HI);
                    1:  r = rd_at(vec - word_t'(4), DST_TOP_LO);
                    2:  r = rd_at(vec - word_t'(1), DST_PC_HI);
                    3:  r = rd_at(vec, DST_PC_LO);
                    4:  r = wr_at(top - word_t'(1), ir);
                    5:  r = wr_at(top - word_t'(3), hi_b(c.sp));
                    6:  r = wr_at(top - word_t'(2), lo_b(c.sp));
                    7:  r = wr_at(top - word_t'(5), hi_b(c.pc));
                    8:  r = wr_at(top - word_t'(4), lo_b(c.pc));
                    9:  r = wr_at(top - word_t'(7), hi_b(c.x));
                    10: r = wr_at(top - word_t'(6), lo_b(c.x));
                    11: r = wr_at(top - word_t'(9), hi_b(c.a));
                    12: r = wr_at(top - word_t'(8), lo_b(c.a));
                    default: r = wr_at(top - word_t'(10),
                                       {{(BYTE_W-FLAG_W){1'b0}}, c.flags});
                endcase
            end
            default: begin
                base = c.sp + word_t'(idx);
                case (idx)
                    0: r = rd_at(base, DST_FLG);
                    1: r = rd_at(base, DST_A_HI);
                    2: r = rd_at(base, DST_A_LO);
                    3: r = rd_at(base, DST_X_HI);
                    4: r = rd_at(base, DST_X_LO);
                    5: r = rd_at(base, DST_PC_HI);
                    6: r = rd_at(base, DST_PC_LO);
                    7: r = rd_at(base, DST_SP_HI);
                    default: r = rd_at(base, DST_SP_LO);
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctxseq_ctrl.sv
module ctxseq_ctrl
    import ctxseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op_i,
    input  logic [NLOC_W-1:0]   n_i,
    output logic                accept,
    output logic                run,
    output logic                last,
    output logic                busy,
    output logic                done,
    output step_t               step,
    output op_e                 op_q,
    output logic [NLOC_W-1:0]   n_q
);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
    state_e state;

    assign accept = (state == ST_IDLE) && start;
    assign run    = (state == ST_RUN);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_FIN);
    assign last   = run && (step == op_steps(op_q) - step_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            op_q  <= OP_CALL;
            n_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    step  <= '0;
                    op_q  <= op_e'(op_i);
                    n_q   <= n_i;
                end
                ST_RUN: begin
                    if (last) state <= ST_FIN;
                    else      step  <= step + step_t'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: step index never passes the operation length
    a_r9_step_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (step < op_steps(op_q)));

    // R10: a running command keeps its operation and local count
    a_r10_cmd_held: assert property (@(posedge clk) disable iff (rst)
        run |=> ($stable(op_q) && $stable(n_q)));

endmodule

// File: rtl/ctxseq_access.sv
module ctxseq_access
    import ctxseq_pkg::*;
#(
    parameter logic [15:0] ROM_BASE = 16'hF000,
    parameter logic [15:0] VEC_BASE = 16'hFFFF
) (
    input  logic              run,
    input  op_e               op_q,
    input  logic [NLOC_W-1:0] n_q,
    input  step_t             step,
    input  ctx_t              snap,
    input  byte_t             snap_ir,
    input  word_t             top_q,
    output logic              mem_en,
    output logic              mem_we,
    output word_t             mem_addr,
    output byte_t             mem_wdata,
    output logic              rd_en,
    output dst_e              rd_dst
);

    access_t acc;

    always_comb begin
        acc = plan_step(op_q, step, n_q, snap, snap_ir, top_q, word_t'(VEC_BASE));
    end

    assign mem_en    = run && acc.en;
    assign mem_we    = mem_en && acc.wr && (acc.addr < word_t'(ROM_BASE));
    assign mem_addr  = acc.addr;
    assign mem_wdata = acc.wdata;
    assign rd_en     = mem_en && !acc.wr;
    assign rd_dst    = acc.dst;

endmodule

// File: rtl/ctxseq_frame.sv
module ctxseq_frame
    import ctxseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              run,
    input  logic              last,
    input  op_e               op_q,
    input  logic [NLOC_W-1:0] n_q,
    input  logic              rd_en,
    input  dst_e              rd_dst,
    input  byte_t             rdata,
    input  ctx_t              cur,
    input  byte_t             cur_ir,
    input  word_t             cur_tgt,
    output ctx_t              snap,
    output byte_t             snap_ir,
    output word_t             top_q,
    output ctx_t              res
);

    word_t tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '0;
            snap_ir <= '0;
            tgt_q   <= '0;
            top_q   <= '0;
            res     <= '0;
        end else if (accept) begin
            snap    <= cur;
            snap_ir <= cur_ir;
            tgt_q   <= cur_tgt;
            top_q   <= '0;
            res     <= cur;
        end else if (run) begin
            if (rd_en) begin
                case (rd_dst)
                    DST_PC_HI:  res.pc[WORD_W-1 -: BYTE_W] <= rdata;
                    DST_PC_LO:  res.pc[BYTE_W-1:0]         <= rdata;
                    DST_TOP_HI: top_q[WORD_W-1 -: BYTE_W]  <= rdata;
                    DST_TOP_LO: top_q[BYTE_W-1:0]          <= rdata;
                    DST_FLG:    res.flags                  <= rdata[FLAG_W-1:0];
                    DST_A_HI:   res.a[WORD_W-1 -: BYTE_W]  <= rdata;
                    DST_A_LO:   res.a[BYTE_W-1:0]          <= rdata;
                    DST_X_HI:   res.x[WORD_W-1 -: BYTE_W]  <= rdata;
                    DST_X_LO:   res.x[BYTE_W-1:0]          <= rdata;
                    DST_SP_HI:  res.sp[WORD_W-1 -: BYTE_W] <= rdata;
                    DST_SP_LO:  res.sp[BYTE_W-1:0]         <= rdata;
                    default: ;
                endcase
            end
            if (last) begin
                case (op_q)
                    OP_CALL: begin
                        res.sp <= snap.sp + word_t'(16'hFFFE);
                        res.pc <= tgt_q;
                    end
                    OP_RET:  res.sp <= snap.sp + word_t'(n_q) + word_t'(2);
                    OP_TRAP: res.sp <= top_q - word_t'(10);
                    default: ;
                endcase
            end
        end
    end

    // R1: a finished call leaves SP two below the snapshot
    a_r1_call_sp: assert property (@(posedge clk) disable iff (rst)
        (run && last && op_q == OP_CALL) |=> (res.sp + word_t'(2) == snap.sp));

    // R5: trap entry does not disturb A, X or flags
    a_r5_trap_keeps_ax: assert property (@(posedge clk) disable iff (rst)
        (run && last && op_q == OP_TRAP) |=> (res.a == snap.a && res.x == snap.x
                                              && res.flags == snap.flags));

endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
    import ctxseq_pkg::*;
#(
    parameter logic [15:0] ROM_BASE = 16'hF000,
    parameter logic [15:0] VEC_BASE = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [2:0]  ret_n,
    input  logic [15:0] cur_sp,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_a,
    input  logic [15:0] cur_x,
    input  logic [3:0]  cur_flags,
    input  logic [7:0]  cur_ir,
    input  logic [15:0] call_target,
    output logic        busy,
    output logic        done,
    output logic [15:0] res_sp,
    output logic [15:0] res_pc,
    output logic [15:0] res_a,
    output logic [15:0] res_x,
    output logic [3:0]  res_flags,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);

    logic              accept, run, last, rd_en;
    step_t             step;
    op_e               op_q;
    logic [NLOC_W-1:0] n_q;
    ctx_t              cur_ctx, snap, res;
    byte_t             snap_ir;
    word_t             top_q;
    dst_e              rd_dst;

    always_comb begin
        cur_ctx.sp    = cur_sp;
        cur_ctx.pc    = cur_pc;
        cur_ctx.a     = cur_a;
        cur_ctx.x     = cur_x;
        cur_ctx.flags = cur_flags;
    end

    ctxseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_i(op), .n_i(ret_n),
        .accept(accept), .run(run), .last(last), .busy(busy), .done(done),
        .step(step), .op_q(op_q), .n_q(n_q)
    );

    ctxseq_access #(.ROM_BASE(ROM_BASE), .VEC_BASE(VEC_BASE)) u_access (
        .run(run), .op_q(op_q), .n_q(n_q), .step(step), .snap(snap),
        .snap_ir(snap_ir), .top_q(top_q), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_en(rd_en), .rd_dst(rd_dst)
    );

    ctxseq_frame u_frame (
        .clk(clk), .rst(rst), .accept(accept), .run(run), .last(last),
        .op_q(op_q), .n_q(n_q), .rd_en(rd_en), .rd_dst(rd_dst),
        .rdata(mem_rdata), .cur(cur_ctx), .cur_ir(cur_ir), .cur_tgt(call_target),
        .snap(snap), .snap_ir(snap_ir), .top_q(top_q), .res(res)
    );

    assign res_sp    = res.sp;
    assign res_pc    = res.pc;
    assign res_a     = res.a;
    assign res_x     = res.x;
    assign res_flags = res.flags;

    // R11: no memory traffic outside a command
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    // R8: a write strobe only comes with an access
    a_r8_we_with_en: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    // R2: return and return-from-trap never write
    a_r2_ret_reads_only: assert property (@(posedge clk) disable iff (rst)
        (mem_en && (op_q == OP_RET || op_q == OP_RETTR)) |-> !mem_we);

endmodule

// File: tb/test_ctx_sequencer.sv
module test_ctx_sequencer;

    localparam logic [15:0] ROM = 16'hF000;
    localparam logic [15:0] VEC = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [2:0]  ret_n = 3'd0;
    logic [15:0] r_sp = '0, r_pc = '0, r_a = '0, r_x = '0, r_tgt = '0;
    logic [3:0]  r_f = '0;
    logic [7:0]  r_ir = '0;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] res_sp, res_pc, res_a, res_x, mem_addr;
    logic [3:0]  res_flags;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int en_cnt = 0;
    int rom_we_cnt = 0;
    logic [7:0] mem [int];

    always #5 clk = ~clk;

    ctx_sequencer #(.ROM_BASE(ROM), .VEC_BASE(VEC)) i_ctx_sequencer (
        .clk(clk), .rst(rst), .start(start), .op(op_i), .ret_n(ret_n),
        .cur_sp(r_sp), .cur_pc(r_pc), .cur_a(r_a), .cur_x(r_x),
        .cur_flags(r_f), .cur_ir(r_ir), .call_target(r_tgt),
        .busy(busy), .done(done), .res_sp(res_sp), .res_pc(res_pc),
        .res_a(res_a), .res_x(res_x), .res_flags(res_flags),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mrd(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_en) en_cnt++;
        if (mem_en && mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            if (mem_addr >= ROM) rom_we_cnt++;
        end
    end

    always @(negedge clk) mem_rdata <= mrd(mem_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // poke_at: cycle after start where a second start is raised (0 = none)
    task automatic issue(input logic [1:0] o, input logic [2:0] n, input int poke_at,
                         input bit poke_done, output int cyc);
        int guard;
        @(negedge clk);
        op_i = o; ret_n = n; start = 1'b1; en_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        guard = 1;
        while (!done && guard < 100) begin
            if (guard == poke_at) begin start = 1'b1; op_i = o ^ 2'b01; end
            else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        if (guard >= 100) chk("R9 done never seen", 32'd0, 32'd1);
        cyc = en_cnt;
        if (poke_done) begin
            start = 1'b1; op_i = 2'd2;
            @(negedge clk);
            start = 1'b0;
            en_cnt = 0;
            repeat (3) @(negedge clk);
            chk("R10 start in done cycle caused accesses", en_cnt, 0);
            chk("R10 start in done cycle made busy", busy, 0);
        end
    endtask

    task automatic call_ret(input logic [15:0] sp0, input logic [15:0] pc0,
                            input logic [15:0] tgt, input logic [2:0] n);
        int cyc;
        logic [15:0] a0, x0;
        logic [3:0] f0;
        a0 = 16'($urandom); x0 = 16'($urandom); f0 = 4'($urandom);
        r_sp = sp0; r_pc = pc0; r_tgt = tgt; r_a = a0; r_x = x0; r_f = f0;
        issue(2'd0, 3'd0, 0, 1'b0, cyc);
        chk("R9 call access count", cyc, 2);
        chk("R1 call SP", res_sp, sp0 - 16'd2);
        chk("R1 call PC", res_pc, tgt);
        chk("R1 call A/X/flags", {res_a, res_x, 12'h0, res_flags}, {a0, x0, 12'h0, f0});
        chk("R1 pushed PC", {mrd(sp0 - 16'd2), mrd(sp0 - 16'd1)}, pc0);
        r_sp = res_sp - 16'(n); r_pc = res_pc;
        issue(2'd1, n, 0, 1'b0, cyc);
        chk("R9 return access count", cyc, 2);
        chk("R2 return PC restored", res_pc, pc0);
        chk("R2 return SP restored", res_sp, sp0);
        chk("R2 return A/X/flags", {res_a, res_x, 12'h0, res_flags}, {a0, x0, 12'h0, f0});
    endtask

    task automatic trap_pair(input logic [15:0] top, input int poke_at, input bit poke_done);
        int cyc;
        logic [15:0] sp0, pc0, a0, x0, hdl, ad, e_sp;
        logic [3:0] f0;
        logic [7:0] ir0;
        logic [7:0] pre [1:10];
        logic [7:0] eb [1:10];
        sp0 = 16'h0400 + 16'($urandom % 32'h8000); pc0 = 16'($urandom);
        a0 = 16'($urandom); x0 = 16'($urandom); f0 = 4'($urandom);
        ir0 = 8'($urandom); hdl = 16'($urandom);
        mem[int'(VEC - 16'd5)] = top[15:8]; mem[int'(VEC - 16'd4)] = top[7:0];
        mem[int'(VEC - 16'd1)] = hdl[15:8]; mem[int'(VEC)] = hdl[7:0];
        for (int i = 1; i <= 10; i++) pre[i] = mrd(top - 16'(i));
        eb[1] = ir0; eb[2] = sp0[7:0]; eb[3] = sp0[15:8]; eb[4] = pc0[7:0];
        eb[5] = pc0[15:8]; eb[6] = x0[7:0]; eb[7] = x0[15:8]; eb[8] = a0[7:0];
        eb[9] = a0[15:8]; eb[10] = {4'h0, f0};
        r_sp = sp0; r_pc = pc0; r_a = a0; r_x = x0; r_f = f0; r_ir = ir0;
        issue(2'd2, 3'd0, poke_at, poke_done, cyc);
        chk("R9 trap access count", cyc, 14);
        chk("R3 trap PC from handler vector", res_pc, hdl);
        chk("R5 trap SP", res_sp, top - 16'd10);
        chk("R5 trap A/X/flags", {res_a, res_x, 12'h0, res_flags}, {a0, x0, 12'h0, f0});
        for (int i = 1; i <= 10; i++) begin
            ad = top - 16'(i);
            if (ad < ROM) chk("R4 frame byte", {ad, mrd(ad)}, {ad, eb[i]});
            else          chk("R8 ROM frame byte kept", {ad, mrd(ad)}, {ad, pre[i]});
        end
        e_sp = (top - 16'd3 < ROM) ? sp0 : {pre[3], pre[2]};
        r_sp = res_sp; r_pc = res_pc; r_a = ~a0; r_x = 16'($urandom); r_f = ~f0;
        issue(2'd3, 3'd0, 0, 1'b0, cyc);
        chk("R9 return-from-trap access count", cyc, 9);
        chk("R6 flags restored", res_flags, f0);
        chk("R7 A restored", res_a, a0);
        chk("R7 X restored", res_x, x0);
        chk("R7 PC restored", res_pc, pc0);
        chk("R7 SP restored", res_sp, e_sp);
    endtask

    initial begin
        #2_000_000;
        checks++; failures++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset mem_en", mem_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 idle mem_en", mem_en, 0);

        call_ret(16'h8000, 16'h1234, 16'h4000, 3'd5);
        call_ret(16'h0300, 16'hABCD, 16'h0010, 3'd0);
        call_ret(16'h2000, 16'h00FF, 16'hFFF0, 3'd7);

        // R12: return whose reads cross the top of the address space
        mem[0] = 8'h5E; mem[1] = 8'h71;
        r_sp = 16'hFFFD; r_pc = 16'h0000;
        issue(2'd1, 3'd3, 0, 1'b0, cyc);
        chk("R12 wrapped return PC", res_pc, 16'h5E71);
        chk("R12 wrapped return SP", res_sp, 16'h0002);

        trap_pair(16'h6000, 0, 1'b0);
        // R10: a new start mid-trap and one in the done cycle
        trap_pair(16'h3100, 4, 1'b1);
        // R8: frame straddling the ROM boundary
        mem[int'(ROM)] = 8'hA5; mem[int'(ROM + 16'd1)] = 8'h5A; mem[int'(ROM + 16'd2)] = 8'h3C;
        trap_pair(ROM + 16'd3, 0, 1'b0);

        for (int i = 0; i < 15; i++)
            call_ret(16'h0200 + 16'($urandom % 32'hC000), 16'($urandom),
                     16'($urandom), 3'($urandom));
        for (int i = 0; i < 8; i++)
            trap_pair(16'h1000 + 16'($urandom % 32'hD000), 0, 1'b0);

        chk("R8 no write at or above ROM boundary", rom_we_cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule